// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

The block is a memory-mapped calendar clock. It keeps seconds, minutes, hours, a day of week, a day of month, a month and a two-digit year, and moves the whole calendar forward by one second on each cycle where the `tick` input is high. Carries pass from seconds up to the year. The month length depends on the month, and February also depends on a leap rule. A second register set holds an alarm time. When the running time reaches the alarm time, a pending flag is latched and the interrupt output is driven.

Software reaches the block through a simple word-addressed bus. Each cycle may carry one read or one write, and read data comes back one cycle later. The counter stays frozen until seven key bytes have been written to seven key addresses in a fixed order. After that, a stop bit lets software hold the counter while it loads a new time. The alarm is armed by writing its control byte. Writing zero to that byte disarms the alarm and masks the interrupt.

Top module: `cal_rtc`

## Requirements
- R1: The counter is locked after reset. It unlocks once these writes have been made in this order, comparing only `wdata[7:0]`: 0xC6 to 0x04, 0x9A to 0x08, 0x59 to 0x0C, 0xA3 to 0x10, 0x57 to 0x14, 0x67 to 0x18, 0xD2 to 0x1C. Any write to one of these seven addresses that does not match the expected step restarts the sequence. If that write is itself the first key, it counts as step one. Once unlocked, the block stays unlocked until reset.
- R2: The calendar advances exactly one second at the clock edge where `tick` is high, provided the block is unlocked and the stop bit is clear. In every other cycle the calendar holds, unless software writes a time field.
- R3: Seconds and minutes wrap from 59 to 0, and each wrap carries into the next field. Hours wrap from 23 to 0 and carry into the day.
- R4: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is nonzero and divisible by 4; otherwise it has 28, and year 0 always gives 28. All other months have 31 days. After the last day of a month, the day returns to 1 and the month increments.
- R5: Month 12 rolls over to month 1 and increments the year. Year 99 wraps to 0.
- R6: The day-of-week field counts 0 to 6. It advances by one at each day rollover, and 6 wraps to 0.
- R7: Calendar field registers sit at 0x40 + 4*f + 0x20*s. The field index f runs 0 to 6 as year, month, day of month, day of week, hour, minute, second. The set s is 0 for the running time and 1 for the alarm. A read returns data on `bus_rdata` one cycle after the request. Unmapped addresses read 0. Reset values are year 1, month 1, day 1, day of week 0 and 00:00:00, for both sets.
- R8: When a counting step produces a time equal to the alarm in all seven fields and the alarm is enabled, bit 4 of the status register at 0x30 is set on that same edge. `alarm_irq` is high while that bit is set and the alarm is enabled.
- R9: Writing 1 to bit 4 of 0x30 clears the pending flag. If a new match arrives in the same cycle, the set wins.
- R10: The alarm control register at 0x7C is 8 bits wide, reads back as written and resets to 0. Bit 0 enables the alarm. While bit 0 is 0, no match is taken and `alarm_irq` is low, but a flag that is already pending is kept.
- R11: The register at 0x2C holds a 3-bit debounce value in bits [2:0]. It reads back as written and resets to 0.
- R12: Bit 0 of 0x20 is the stop bit, which resets to 0. A write to a time field takes effect at its edge, whether or not the counter is stopped. If a counting tick arrives in the same cycle, the write wins and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance strobe |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
A bus write or a counting tick changes state at the next rising edge, so any later read sees the new value. A read itself delivers its data one edge after the request. The pending flag and `alarm_irq` change at the same edge as the tick that completes the match. The bench therefore drives every input on the falling edge and releases it one falling edge later, so results are sampled half a cycle after the edge that produced them. The calendar corner cases come from one table of start dates with independently worked-out successor dates, each loaded while stopped and advanced by exactly one tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS   = 7;
  localparam int UNLOCK_STEPS = 7;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mo;
    logic [4:0] dm;
    logic [2:0] dw;
    logic [4:0] hr;
    logic [5:0] mi;
    logic [5:0] se;
  } cal_t;

  localparam cal_t CAL_RESET = '{yr: 7'd1, mo: 4'd1, dm: 5'd1, dw: 3'd0,
                                 hr: 5'd0, mi: 6'd0, se: 6'd0};

  // Bus address of unlock step i.
  function automatic logic [7:0] key_addr(input logic [2:0] i);
    return 8'h04 + {3'b000, i, 2'b00};
  endfunction

  // Byte that unlock step i expects.
  function automatic logic [7:0] key_byte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'hC6;
      3'd1:    return 8'h9A;
      3'd2:    return 8'h59;
      3'd3:    return 8'hA3;
      3'd4:    return 8'h57;
      3'd5:    return 8'h67;
      default: return 8'hD2;
    endcase
  endfunction

  // Year 0 is never a leap year.
  function automatic logic is_leap(input logic [6:0] yr);
    return (yr != 7'd0) && (yr[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mo, input logic [6:0] yr);
    case (mo)
      4'd2:                    return is_leap(yr) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction

  // Successor of a calendar value after one second.
  function automatic cal_t cal_next(input cal_t c, input logic [6:0] ylast);
    cal_t n;
    n = c;
    if (c.se != 6'd59) n.se = c.se + 6'd1;
    else begin
      n.se = 6'd0;
      if (c.mi != 6'd59) n.mi = c.mi + 6'd1;
      else begin
        n.mi = 6'd0;
        if (c.hr != 5'd23) n.hr = c.hr + 5'd1;
        else begin
          n.hr = 5'd0;
          n.dw = (c.dw >= 3'd6) ? 3'd0 : c.dw + 3'd1;
          if (c.dm < month_days(c.mo, c.yr)) n.dm = c.dm + 5'd1;
          else begin
            n.dm = 5'd1;
            if (c.mo < 4'd12) n.mo = c.mo + 4'd1;
            else begin
              n.mo = 4'd1;
              n.yr = (c.yr >= ylast) ? 7'd0 : c.yr + 7'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic [6:0] get_field(input cal_t c, input logic [2:0] idx);
    case (idx)
      3'd0:    return c.yr;
      3'd1:    return {3'b000, c.mo};
      3'd2:    return {2'b00, c.dm};
      3'd3:    return {4'b0000, c.dw};
      3'd4:    return {2'b00, c.hr};
      3'd5:    return {1'b0, c.mi};
      3'd6:    return {1'b0, c.se};
      default: return 7'd0;
    endcase
  endfunction

  function automatic cal_t put_field(input cal_t c, input logic [2:0] idx, input logic [6:0] v);
    cal_t n;
    n = c;
    case (idx)
      3'd0:    n.yr = v;
      3'd1:    n.mo = v[3:0];
      3'd2:    n.dm = v[4:0];
      3'd3:    n.dw = v[2:0];
      3'd4:    n.hr = v[4:0];
      3'd5:    n.mi = v[5:0];
      3'd6:    n.se = v[5:0];
      default: n = c;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rtc_unlock.sv
module rtc_unlock
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  output logic              unlocked
);

  localparam int STEP_W = $clog2(UNLOCK_STEPS + 1);

  logic [STEP_W-1:0] step_q;
  logic              key_wr;
  logic              match_cur;
  logic              match_first;

  assign unlocked    = (step_q == STEP_W'(UNLOCK_STEPS));
  assign key_wr      = wr && !unlocked && (addr[1:0] == 2'b00) &&
                       (addr >= ADDR_W'(key_addr(3'd0))) &&
                       (addr <= ADDR_W'(key_addr(3'(UNLOCK_STEPS - 1))));
  assign match_cur   = (addr == ADDR_W'(key_addr(3'(step_q)))) &&
                       (wbyte == key_byte(3'(step_q)));
  assign match_first = (addr == ADDR_W'(key_addr(3'd0))) &&
                       (wbyte == key_byte(3'd0));

  always_ff @(posedge clk) begin
    if (!rst_n)      step_q <= '0;
    else if (key_wr) begin
      if (match_cur)        step_q <= step_q + STEP_W'(1);
      else if (match_first) step_q <= STEP_W'(1);
      else                  step_q <= '0;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int YEAR_LAST = 99
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [6:0] wr_val,
  output cal_t       now,
  output cal_t       nxt,
  output logic       adv
);

  cal_t cal_q;

  assign now = cal_q;
  assign nxt = cal_next(cal_q, 7'(YEAR_LAST));
  assign adv = step && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n)     cal_q <= CAL_RESET;
    else if (wr_en) cal_q <= put_field(cal_q, wr_idx, wr_val);
    else if (adv)   cal_q <= nxt;
  end

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  cal_t nxt,
  input  cal_t alm,
  input  logic en,
  input  logic clr,
  output logic hit,
  output logic pending
);

  assign hit = adv && en && (nxt == alm);

  always_ff @(posedge clk) begin
    if (!rst_n)   pending <= 1'b0;
    else if (hit) pending <= 1'b1;
    else if (clr) pending <= 1'b0;
  end

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int YEAR_LAST = 99,
  parameter int DEB_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_irq
);

  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_DEB  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_ACTL = ADDR_W'(8'h7C);
  localparam int BANK_W   = ADDR_W - 5;
  localparam int PEND_BIT = 4;

  logic wr, rd, aligned;
  logic [BANK_W-1:0] bank;
  logic [2:0] fidx;
  logic fvalid, time_wr, alm_wr;
  logic ctl_wr, deb_wr, stat_wr, actl_wr;
  logic stop_q;
  logic [DEB_W-1:0] deb_q;
  logic [7:0] actl_q;
  logic unlocked, run_step, adv, hit, pending, clr;
  cal_t cur, nxt, alm_q;
  logic [DATA_W-1:0] rd_mux;
  logic wdata_unused;

  assign wr      = bus_req && bus_we;
  assign rd      = bus_req && !bus_we;
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign bank    = bus_addr[ADDR_W-1:5];
  assign fidx    = bus_addr[4:2];
  assign fvalid  = aligned && (fidx < 3'(NUM_FIELDS));
  assign time_wr = wr && fvalid && (bank == BANK_W'(2));
  assign alm_wr  = wr && fvalid && (bank == BANK_W'(3));
  assign ctl_wr  = wr && (bus_addr == A_CTL);
  assign deb_wr  = wr && (bus_addr == A_DEB);
  assign stat_wr = wr && (bus_addr == A_STAT);
  assign actl_wr = wr && (bus_addr == A_ACTL);
  assign clr     = stat_wr && bus_wdata[PEND_BIT];
  assign wdata_unused = ^bus_wdata[DATA_W-1:8];

  rtc_unlock #(.ADDR_W(ADDR_W)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(bus_addr),
    .wbyte(bus_wdata[7:0]), .unlocked(unlocked)
  );

  assign run_step = tick && unlocked && !stop_q;

  rtc_calendar #(.YEAR_LAST(YEAR_LAST)) u_cal (
    .clk(clk), .rst_n(rst_n), .step(run_step), .wr_en(time_wr),
    .wr_idx(fidx), .wr_val(bus_wdata[6:0]), .now(cur), .nxt(nxt), .adv(adv)
  );

  rtc_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .adv(adv), .nxt(nxt), .alm(alm_q),
    .en(actl_q[0]), .clr(clr), .hit(hit), .pending(pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      deb_q  <= '0;
      actl_q <= '0;
      alm_q  <= CAL_RESET;
    end else begin
      if (ctl_wr)  stop_q <= bus_wdata[0];
      if (deb_wr)  deb_q  <= bus_wdata[DEB_W-1:0];
      if (actl_wr) actl_q <= bus_wdata[7:0];
      if (alm_wr)  alm_q  <= put_field(alm_q, fidx, bus_wdata[6:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (fvalid && bank == BANK_W'(2))      rd_mux = DATA_W'(get_field(cur, fidx));
    else if (fvalid && bank == BANK_W'(3)) rd_mux = DATA_W'(get_field(alm_q, fidx));
    else if (bus_addr == A_CTL)            rd_mux = DATA_W'(stop_q);
    else if (bus_addr == A_DEB)            rd_mux = DATA_W'(deb_q);
    else if (bus_addr == A_STAT)           rd_mux = DATA_W'(pending) << PEND_BIT;
    else if (bus_addr == A_ACTL)           rd_mux = DATA_W'(actl_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  assign alarm_irq = pending && actl_q[0];

endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic unlocked,
  input logic adv,
  input logic time_wr,
  input cal_t cur,
  input logic hit,
  input logic pending,
  input logic clr,
  input logic al_en
);

  // R1
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  // R2
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !adv);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !time_wr) |=> $stable(cur));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cur.se == 6'd59) |=> (cur.se == 6'd0));

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pending);

  // R9
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !pending);

  // R10
  no_hit_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !al_en |-> !hit);

endmodule

bind cal_rtc rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .adv(adv), .time_wr(time_wr),
  .cur(cur), .hit(hit), .pending(pending), .clr(clr), .al_en(actl_q[0])
);

// File: tb/cal_rtc_test.sv
module cal_rtc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  cal_rtc uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq)
  );

  typedef struct packed {
    logic [6:0] y;  logic [3:0] m;  logic [4:0] d;  logic [2:0] w;
    logic [6:0] ey; logic [3:0] em; logic [4:0] ed; logic [2:0] ew;
  } vec_t;

  // Start date at 23:59:59 and the date expected one tick later.
  localparam vec_t VEC [10] = '{
    '{7'd1,  4'd1,  5'd31, 3'd2, 7'd1,  4'd2,  5'd1,  3'd3},
    '{7'd1,  4'd2,  5'd28, 3'd6, 7'd1,  4'd3,  5'd1,  3'd0},
    '{7'd4,  4'd2,  5'd28, 3'd1, 7'd4,  4'd2,  5'd29, 3'd2},
    '{7'd4,  4'd2,  5'd29, 3'd2, 7'd4,  4'd3,  5'd1,  3'd3},
    '{7'd0,  4'd2,  5'd28, 3'd4, 7'd0,  4'd3,  5'd1,  3'd5},
    '{7'd1,  4'd4,  5'd30, 3'd0, 7'd1,  4'd5,  5'd1,  3'd1},
    '{7'd1,  4'd4,  5'd29, 3'd5, 7'd1,  4'd4,  5'd30, 3'd6},
    '{7'd99, 4'd12, 5'd31, 3'd3, 7'd0,  4'd1,  5'd1,  3'd4},
    '{7'd5,  4'd12, 5'd31, 3'd6, 7'd6,  4'd1,  5'd1,  3'd0},
    '{7'd2,  4'd6,  5'd30, 3'd1, 7'd2,  4'd7,  5'd1,  3'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // set 0 = running time, set 1 = alarm; field order y,m,d,w,h,mi,s
  task automatic load(input int set, input int y, input int m, input int d,
                      input int w, input int h, input int mi, input int s);
    int v [7];
    v = '{y, m, d, w, h, mi, s};
    if (set == 0) bwr(8'h20, 32'd1);
    for (int i = 0; i < 7; i++)
      bwr(8'(8'h40 + 4 * i + 32 * set), 32'(v[i]));
    if (set == 0) bwr(8'h20, 32'd0);
  endtask

  task automatic unlock_all();
    bwr(8'h04, 32'hC6); bwr(8'h08, 32'h9A); bwr(8'h0C, 32'h59);
    bwr(8'h10, 32'hA3); bwr(8'h14, 32'h57); bwr(8'h18, 32'h67);
    bwr(8'h1C, 32'hD2);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset values
    brd(8'h40, rv); chk("R7 reset year", rv, 1);
    brd(8'h44, rv); chk("R7 reset month", rv, 1);
    brd(8'h48, rv); chk("R7 reset day", rv, 1);
    brd(8'h58, rv); chk("R7 reset second", rv, 0);
    brd(8'h78, rv); chk("R7 reset alarm second", rv, 0);
    brd(8'h30, rv); chk("R8 reset status", rv, 0);
    brd(8'h7C, rv); chk("R10 reset alarm ctl", rv, 0);
    brd(8'h20, rv); chk("R12 reset stop", rv, 0);
    chk("R8 reset irq", 32'(alarm_irq), 0);

    // R1 locked: tick has no effect
    pulse_tick();
    brd(8'h58, rv); chk("R1 locked no advance", rv, 0);
    // R1 wrong byte mid-sequence restarts
    bwr(8'h04, 32'hC6); bwr(8'h08, 32'h9A); bwr(8'h0C, 32'h00);
    bwr(8'h10, 32'hA3); bwr(8'h14, 32'h57); bwr(8'h18, 32'h67);
    bwr(8'h1C, 32'hD2);
    pulse_tick();
    brd(8'h58, rv); chk("R1 bad key stays locked", rv, 0);
    unlock_all();
    pulse_tick();
    brd(8'h58, rv); chk("R1 R2 unlocked advances", rv, 1);
    pulse_tick();
    brd(8'h58, rv); chk("R2 one step per tick", rv, 2);

    // R12 stop holds
    bwr(8'h20, 32'd1);
    brd(8'h20, rv); chk("R12 stop readback", rv, 1);
    pulse_tick();
    brd(8'h58, rv); chk("R12 stopped holds", rv, 2);
    bwr(8'h20, 32'd0);

    // R12 write wins over tick
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h58; bus_wdata = 32'd30; tick = 1'b1;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; tick = 1'b0;
    brd(8'h58, rv); chk("R12 write beats tick", rv, 30);

    // R11 debounce
    bwr(8'h2C, 32'hFF);
    brd(8'h2C, rv); chk("R11 debounce width", rv, 7);

    // R3 minute carry without hour carry
    load(0, 3, 5, 10, 2, 10, 20, 59);
    pulse_tick();
    brd(8'h54, rv); chk("R3 minute carry", rv, 21);
    brd(8'h58, rv); chk("R3 second wrap", rv, 0);
    brd(8'h50, rv); chk("R3 hour unchanged", rv, 10);

    // R4 R5 R6 table of day rollovers
    for (int k = 0; k < 10; k++) begin
      load(0, VEC[k].y, VEC[k].m, VEC[k].d, VEC[k].w, 23, 59, 59);
      pulse_tick();
      brd(8'h40, rv); chk($sformatf("R5 vec%0d year", k), rv, 32'(VEC[k].ey));
      brd(8'h44, rv); chk($sformatf("R4 vec%0d month", k), rv, 32'(VEC[k].em));
      brd(8'h48, rv); chk($sformatf("R4 vec%0d day", k), rv, 32'(VEC[k].ed));
      brd(8'h4C, rv); chk($sformatf("R6 vec%0d dow", k), rv, 32'(VEC[k].ew));
      brd(8'h50, rv); chk($sformatf("R3 vec%0d hour", k), rv, 0);
    end

    // R8 alarm match
    load(0, 10, 3, 5, 1, 8, 0, 0);
    load(1, 10, 3, 5, 1, 8, 0, 2);
    brd(8'h78, rv); chk("R7 alarm field readback", rv, 2);
    bwr(8'h7C, 32'hFF);
    brd(8'h7C, rv); chk("R10 alarm ctl readback", rv, 32'hFF);
    pulse_tick();
    brd(8'h30, rv); chk("R8 no early match", rv, 0);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R8 irq same edge", 32'(alarm_irq), 1);
    brd(8'h30, rv); chk("R8 pending set", rv, 32'h10);

    // R9 clear
    bwr(8'h30, 32'h10);
    chk("R9 irq cleared", 32'(alarm_irq), 0);
    brd(8'h30, rv); chk("R9 pending cleared", rv, 0);

    // R10 zero control masks irq, keeps pending
    load(0, 10, 3, 5, 1, 8, 0, 1);
    pulse_tick();
    chk("R8 refire irq", 32'(alarm_irq), 1);
    bwr(8'h7C, 32'h00);
    chk("R10 masked irq", 32'(alarm_irq), 0);
    brd(8'h30, rv); chk("R10 pending kept", rv, 32'h10);
    bwr(8'h30, 32'h10);
    load(0, 10, 3, 5, 1, 8, 0, 1);
    pulse_tick();
    brd(8'h30, rv); chk("R10 disabled no match", rv, 0);
    chk("R10 disabled irq low", 32'(alarm_irq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule